// File: doc/BRIEF.md
# Scrolling Character-Window Address Mapper

This block turns a character cell on a dot-matrix text panel into the 7-bit address of the display memory byte that holds the cell's character code. The caller gives a zero-based column and a line select. One cycle later the block returns the address to fetch. A fetch sequencer steps the column across the visible window and uses that address to read the display memory. The memory itself and the glyph lookup that follows it are not part of this block.

Two layouts are supported. In single-line layout one run of 80 addresses (0x00..0x4F) forms the line. In dual-line layout the upper line holds addresses 0x00..0x27 and the lower line holds 0x40..0x67, so the two ranges have a gap between them. The block also keeps a scroll offset that moves the visible window. A left-scroll pulse adds one to the offset, so column 0 shows the next higher address. A right-scroll pulse subtracts one. The offset wraps inside the active line span: modulo 80 in single-line layout and modulo 40 in dual-line layout. In dual-line layout both lines scroll together.

A two-state machine follows the layout. Its states are ST_ONE_LINE and ST_TWO_LINE. The transition GO_DUAL (ST_ONE_LINE to ST_TWO_LINE) is taken when the layout input goes high. The transition GO_SINGLE (ST_TWO_LINE to ST_ONE_LINE) is taken when the layout input goes low. Each state otherwise stays in itself (STAY). Either transition clears the scroll offset.

Top module: `disp_pos_mapper`

## Requirements
- R1: While reset is asserted, and after it is released, the address output is 0x00, the scroll offset is zero and the layout state is ST_ONE_LINE.
- R2: In single-line layout with zero offset, column c maps to address c, for c in 0..79.
- R3: In dual-line layout with zero offset, column c maps to address c when line select is 0, and to 0x40 + c when line select is 1, for c in 0..39.
- R4: A left-scroll pulse raises the offset by one, so column 0 then shows the address one higher than before.
- R5: In single-line layout a right-scroll pulse from zero offset makes column 0 show 0x4F and column 1 show 0x00.
- R6: In dual-line layout a right-scroll pulse from zero offset makes column 0 show 0x27 on the upper line and 0x67 on the lower line.
- R7: The offset wraps modulo the line span: 80 left pulses in single-line layout, or 40 in dual-line layout, give the unscrolled mapping back. A column whose sum with the offset reaches the span wraps to the start of its own line.
- R8: A scroll-reset pulse sets the offset to zero and takes priority over a scroll pulse in the same cycle.
- R9: Left and right scroll pulses in the same cycle leave the offset unchanged.
- R10: A change of the layout input moves the state machine into the matching state on the next clock edge and clears the offset.
- R11: The address output is registered. It reflects the column and line select sampled at the previous clock edge and does not change between edges.
- R12: In single-line layout the line select input has no effect on the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_line | input | 1 | Layout select: 0 single-line, 1 dual-line |
| scroll_left | input | 1 | One-cycle pulse that raises the offset |
| scroll_right | input | 1 | One-cycle pulse that lowers the offset |
| scroll_reset | input | 1 | One-cycle pulse that clears the offset |
| line_sel | input | 1 | 0 upper line, 1 lower line (dual-line layout only) |
| col | input | 7 | Zero-based visible column |
| ram_addr | output | 7 | Registered display memory address |

## Verification
The assertions assume that the column input always lies inside the span of the layout currently held in the state machine: below 80 in ST_ONE_LINE and below 40 in ST_TWO_LINE. One assertion checks that assumption directly, and the output-range checks depend on it. The stimulus keeps to it by setting the column to 0 before every layout change. After that it drives only columns that fit the layout that will be active when the column is sampled.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [0:0] {
        ST_ONE_LINE = 1'b0,
        ST_TWO_LINE = 1'b1
    } layout_state_e;

    typedef enum logic [1:0] {
        OFS_HOLD  = 2'd0,
        OFS_INC   = 2'd1,
        OFS_DEC   = 2'd2,
        OFS_CLEAR = 2'd3
    } ofs_op_e;

endpackage

// File: rtl/dpm_scroll_ctrl.sv
module dpm_scroll_ctrl
    import dpm_pkg::*;
#(
    parameter int SPAN_ONE = 80,
    parameter int SPAN_TWO = 40,
    localparam int OFS_W   = $clog2(SPAN_ONE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dual_line,
    input  logic               scroll_left,
    input  logic               scroll_right,
    input  logic               scroll_reset,
    output layout_state_e      state_q,
    output logic [OFS_W-1:0]   ofs_q
);

    layout_state_e      state_d;
    ofs_op_e            op;
    logic               mode_change;
    logic [OFS_W:0]     span;
    logic [OFS_W-1:0]   ofs_d;

    // Next state: GO_DUAL, GO_SINGLE or STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ONE_LINE: if (dual_line)  state_d = ST_TWO_LINE;
            ST_TWO_LINE: if (!dual_line) state_d = ST_ONE_LINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ONE_LINE;
        else        state_q <= state_d;
    end

    assign mode_change = (state_d != state_q);
    assign span = (state_q == ST_TWO_LINE) ? (OFS_W+1)'(SPAN_TWO) : (OFS_W+1)'(SPAN_ONE);

    always_comb begin
        if (scroll_reset || mode_change)        op = OFS_CLEAR;
        else if (scroll_left && !scroll_right)  op = OFS_INC;
        else if (scroll_right && !scroll_left)  op = OFS_DEC;
        else                                    op = OFS_HOLD;
    end

    always_comb begin
        ofs_d = ofs_q;
        unique case (op)
            OFS_HOLD:  ofs_d = ofs_q;
            OFS_INC:   ofs_d = ({1'b0, ofs_q} == span - 1'b1) ? '0 : ofs_q + 1'b1;
            OFS_DEC:   ofs_d = (ofs_q == '0) ? OFS_W'(span - 1'b1) : ofs_q - 1'b1;
            OFS_CLEAR: ofs_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= '0;
        else        ofs_q <= ofs_d;
    end

    assert_offset_in_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ofs_q} < span));

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scroll_reset |=> (ofs_q == '0));

    assert_layout_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_line != (state_q == ST_TWO_LINE)) |=>
            ((ofs_q == '0) && ((state_q == ST_TWO_LINE) == $past(dual_line))));

    assert_both_pulses_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scroll_left && scroll_right && !scroll_reset &&
         (dual_line == (state_q == ST_TWO_LINE))) |=> $stable(ofs_q));

    assert_left_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scroll_left && !scroll_right && !scroll_reset && (ofs_q == '0) &&
         (dual_line == (state_q == ST_TWO_LINE))) |=> (ofs_q == OFS_W'(1)));

endmodule

// File: rtl/dpm_addr_calc.sv
module dpm_addr_calc
    import dpm_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int SPAN_ONE   = 80,
    parameter int SPAN_TWO   = 40,
    parameter int LINE2_BASE = 64,
    localparam int OFS_W     = $clog2(SPAN_ONE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  layout_state_e      state_q,
    input  logic [OFS_W-1:0]   ofs_q,
    input  logic               line_sel,
    input  logic [OFS_W-1:0]   col,
    output logic [ADDR_W-1:0]  addr_q
);

    logic [OFS_W:0]    span;
    logic [OFS_W:0]    sum;
    logic [OFS_W:0]    wrapped;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] addr_d;

    assign span = (state_q == ST_TWO_LINE) ? (OFS_W+1)'(SPAN_TWO) : (OFS_W+1)'(SPAN_ONE);

    always_comb begin
        sum     = {1'b0, col} + {1'b0, ofs_q};
        wrapped = (sum >= span) ? (sum - span) : sum;
        base    = (state_q == ST_TWO_LINE && line_sel) ? ADDR_W'(LINE2_BASE) : '0;
        addr_d  = ADDR_W'(wrapped) + base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assert_col_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, col} < span));

    assert_dual_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWO_LINE) |=>
            ((addr_q < ADDR_W'(SPAN_TWO)) ||
             ((addr_q >= ADDR_W'(LINE2_BASE)) && (addr_q < ADDR_W'(LINE2_BASE + SPAN_TWO)))));

    assert_single_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONE_LINE) |=> (addr_q < ADDR_W'(SPAN_ONE)));

    assert_registered_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(col) && $stable(line_sel) && $stable(ofs_q) && $stable(state_q))
            |=> $stable(addr_q));

endmodule

// File: rtl/disp_pos_mapper.sv
module disp_pos_mapper
    import dpm_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int SPAN_ONE   = 80,
    parameter int SPAN_TWO   = 40,
    parameter int LINE2_BASE = 64,
    localparam int COL_W     = $clog2(SPAN_ONE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_line,
    input  logic              scroll_left,
    input  logic              scroll_right,
    input  logic              scroll_reset,
    input  logic              line_sel,
    input  logic [COL_W-1:0]  col,
    output logic [ADDR_W-1:0] ram_addr
);

    layout_state_e    state_q;
    logic [COL_W-1:0] ofs_q;

    dpm_scroll_ctrl #(
        .SPAN_ONE (SPAN_ONE),
        .SPAN_TWO (SPAN_TWO)
    ) u_scroll (
        .clk          (clk),
        .rst_n        (rst_n),
        .dual_line    (dual_line),
        .scroll_left  (scroll_left),
        .scroll_right (scroll_right),
        .scroll_reset (scroll_reset),
        .state_q      (state_q),
        .ofs_q        (ofs_q)
    );

    dpm_addr_calc #(
        .ADDR_W     (ADDR_W),
        .SPAN_ONE   (SPAN_ONE),
        .SPAN_TWO   (SPAN_TWO),
        .LINE2_BASE (LINE2_BASE)
    ) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .ofs_q    (ofs_q),
        .line_sel (line_sel),
        .col      (col),
        .addr_q   (ram_addr)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> ((ram_addr == '0) && (ofs_q == '0) && (state_q == ST_ONE_LINE)));

endmodule

// File: tb/sim_disp_pos_mapper.sv
module sim_disp_pos_mapper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dual_line = 1'b0;
    logic       scroll_left = 1'b0;
    logic       scroll_right = 1'b0;
    logic       scroll_reset = 1'b0;
    logic       line_sel = 1'b0;
    logic [6:0] col = 7'd0;
    logic [6:0] ram_addr;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    disp_pos_mapper u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .dual_line    (dual_line),
        .scroll_left  (scroll_left),
        .scroll_right (scroll_right),
        .scroll_reset (scroll_reset),
        .line_sel     (line_sel),
        .col          (col),
        .ram_addr     (ram_addr)
    );

    // Vector fields: [17] layout, [16:15] op (0 none, 1 left, 2 right, 3 reset),
    // [14] line, [13:7] column, [6:0] expected address
    localparam int NV = 25;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 2'd0, 1'b0, 7'd0,  7'h00},
        {1'b0, 2'd0, 1'b0, 7'd79, 7'h4F},
        {1'b0, 2'd0, 1'b1, 7'd5,  7'h05},
        {1'b0, 2'd1, 1'b0, 7'd0,  7'h01},
        {1'b0, 2'd0, 1'b0, 7'd79, 7'h00},
        {1'b0, 2'd2, 1'b0, 7'd0,  7'h00},
        {1'b0, 2'd2, 1'b0, 7'd0,  7'h4F},
        {1'b0, 2'd0, 1'b0, 7'd1,  7'h00},
        {1'b0, 2'd0, 1'b0, 7'd2,  7'h01},
        {1'b0, 2'd3, 1'b0, 7'd0,  7'h00},
        {1'b1, 2'd0, 1'b0, 7'd0,  7'h00},
        {1'b1, 2'd0, 1'b1, 7'd0,  7'h40},
        {1'b1, 2'd0, 1'b0, 7'd15, 7'h0F},
        {1'b1, 2'd0, 1'b1, 7'd15, 7'h4F},
        {1'b1, 2'd0, 1'b1, 7'd39, 7'h67},
        {1'b1, 2'd2, 1'b0, 7'd0,  7'h27},
        {1'b1, 2'd0, 1'b1, 7'd0,  7'h67},
        {1'b1, 2'd0, 1'b1, 7'd1,  7'h40},
        {1'b1, 2'd1, 1'b0, 7'd0,  7'h00},
        {1'b1, 2'd1, 1'b0, 7'd0,  7'h01},
        {1'b1, 2'd0, 1'b0, 7'd39, 7'h00},
        {1'b1, 2'd0, 1'b1, 7'd39, 7'h40},
        {1'b1, 2'd0, 1'b0, 7'd15, 7'h10},
        {1'b1, 2'd0, 1'b1, 7'd15, 7'h50},
        {1'b0, 2'd0, 1'b0, 7'd3,  7'h03}
    };

    task automatic check(input logic [6:0] exp, input string tag);
        n_chk++;
        if (ram_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, ram_addr, exp);
        end
    endtask

    task automatic probe(input logic ln, input logic [6:0] c, input logic [6:0] exp, input string tag);
        line_sel = ln;
        col      = c;
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic pulse(input logic l, input logic r, input logic z);
        scroll_left  = l;
        scroll_right = r;
        scroll_reset = z;
        @(negedge clk);
        scroll_left  = 1'b0;
        scroll_right = 1'b0;
        scroll_reset = 1'b0;
    endtask

    task automatic set_layout(input logic m);
        col       = 7'd0;
        line_sel  = 1'b0;
        dual_line = m;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        col = 7'd7;
        repeat (3) @(negedge clk);
        check(7'h00, "R1 address held at zero in reset");
        rst_n = 1'b1;
        col   = 7'd0;
        @(negedge clk);
        check(7'h00, "R1 zero after reset release");

        // R11 registered output
        probe(1'b0, 7'd7, 7'h07, "R11 first sample");
        col = 7'd9;
        #1;
        check(7'h07, "R11 output steady before edge");
        @(negedge clk);
        check(7'h09, "R11 new column after one edge");
        col = 7'd0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][17] != dual_line) set_layout(VEC[i][17]);
            case (VEC[i][16:15])
                2'd1: pulse(1'b1, 1'b0, 1'b0);
                2'd2: pulse(1'b0, 1'b1, 1'b0);
                2'd3: pulse(1'b0, 1'b0, 1'b1);
                default: ;
            endcase
            probe(VEC[i][14], VEC[i][13:7], VEC[i][6:0],
                  $sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R10 R12)", i));
        end

        // R9 simultaneous left and right
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b1, 1'b0);
        probe(1'b0, 7'd0, 7'h01, "R9 both pulses hold offset");

        // R8 reset wins over scroll
        pulse(1'b1, 1'b0, 1'b1);
        probe(1'b0, 7'd0, 7'h00, "R8 reset beats left");
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1, 1'b1);
        probe(1'b0, 7'd0, 7'h00, "R8 reset beats right");

        // R7 full wrap in single-line layout
        repeat (80) pulse(1'b1, 1'b0, 1'b0);
        probe(1'b0, 7'd0, 7'h00, "R7 80 left pulses wrap");
        probe(1'b0, 7'd79, 7'h4F, "R7 last column after wrap");

        // R10 layout change clears offset
        repeat (3) pulse(1'b1, 1'b0, 1'b0);
        probe(1'b0, 7'd0, 7'h03, "R4 three left pulses");
        set_layout(1'b1);
        probe(1'b1, 7'd0, 7'h40, "R10 switch to dual clears offset");

        // R7 full wrap in dual-line layout
        repeat (40) pulse(1'b1, 1'b0, 1'b0);
        probe(1'b0, 7'd0, 7'h00, "R7 40 left pulses wrap");
        probe(1'b1, 7'd39, 7'h67, "R7 lower line end after wrap");

        // R6 right wrap reached through long decrement
        repeat (41) pulse(1'b0, 1'b1, 1'b0);
        probe(1'b0, 7'd0, 7'h27, "R6 upper line after right wrap");
        probe(1'b1, 7'd0, 7'h67, "R6 lower line after right wrap");

        set_layout(1'b0);
        probe(1'b0, 7'd5, 7'h05, "R10 switch to single clears offset");

        // R12 line select ignored with offset applied
        pulse(1'b1, 1'b0, 1'b0);
        probe(1'b1, 7'd5, 7'h06, "R12 line select ignored");
        probe(1'b0, 7'd5, 7'h06, "R12 same address upper select");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule